// File: doc/BRIEF.md
# Command Stream Register Decoder

This block sits in front of an engine's register file and turns a stream of 32-bit command words into individual register writes. Each command begins with a header word whose upper four bits select the operation. A header either loads a pending payload count, or opens a write burst, which then takes the following words as data. A burst writes its data either to successive register addresses or to one fixed address.

Register offsets in headers are word addresses, so the engine's byte address divided by four. A data word aimed at register address 0 is not forwarded to the register file. It leaves the block as a sync-point increment carrying an index and a condition, and a producer ends each stream with one of these to signal completion. Words arrive over a valid/ready handshake. Register writes leave through a single output slot that the register file drains with its own ready, so backpressure reaches the input without dropping a word. A header with an unrecognised opcode is skipped on its own and sets a sticky error flag.

Top module: `cmd_stream_decoder`

## Requirements
- R1: The opcode is taken from bits 31:28 of a header word. Opcode 9 stores bits PAYLOAD_W-1:0 as the pending payload count and produces no output.
- R2: Opcode 10 opens an incrementing burst at the word offset in bits 21:0. It consumes as many data words as the pending payload count and writes them to offset, offset+1, offset+2 and so on.
- R3: Opcode 11 opens a fixed-address burst at the offset in bits 21:0. It writes every one of the pending-count data words to that same offset.
- R4: Opcode 1 opens an incrementing burst with its offset in bits 27:16 and its own word count in bits 15:0, independent of the pending payload.
- R5: Opcode 2 opens a fixed-address burst with its offset in bits 27:16 and its count in bits 15:0.
- R6: The pending payload count is one-shot: an opcode 10 or 11 header resets it to zero. A wide header that meets a count of zero consumes no data words, and the next word is decoded as a header.
- R7: A short header (opcode 1 or 2) with a count of zero consumes no data words, and the next word is decoded as a header.
- R8: A data word whose target address is 0 raises sync_valid for one cycle, with sync_index equal to data bits 9:0 and sync_cond equal to data bits 17:10. It never appears as a register write.
- R9: An accepted data word is presented on the write port from the next cycle. While reg_wr_valid is high and reg_wr_ready low, the address and data hold, cmd_ready stays low during a burst, and no data word is lost or reordered.
- R10: A header with any other opcode sets err_flag, which stays set until reset. That word alone is skipped, and the next word is decoded as a header.
- R11: After reset no write or sync is presented, err_flag is 0, the pending count is 0, and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word accepted this cycle when valid |
| cmd_word | input | 32 | Command word |
| reg_wr_valid | output | 1 | Register write presented |
| reg_wr_ready | input | 1 | Register file takes the write |
| reg_wr_addr | output | ADDR_W | Register word address |
| reg_wr_data | output | 32 | Register write data |
| sync_valid | output | 1 | One-cycle sync-point increment |
| sync_index | output | SYNC_IDX_W | Sync-point index |
| sync_cond | output | SYNC_COND_W | Increment condition |
| err_flag | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench builds the block with ADDR_W of 22, PAYLOAD_W of 16 and the one-shot payload variant. With these values the widest offset, 0x3FFFFF, and the top short offset, 0xFFF, can be reached, and a header word left over after a cleared payload becomes visible. A pseudo-random ready pattern on the write port stalls the block mid-burst, and a burst that starts at address 0 mixes a sync increment with register writes in one stream.

// File: rtl/csd_pkg.sv
package csd_pkg;

   localparam int unsigned WORD_W      = 32;
   localparam int unsigned OPC_MSB     = 31;
   localparam int unsigned OPC_LSB     = 28;
   localparam int unsigned WIDE_OFF_W  = 22;
   localparam int unsigned SHORT_OFF_W = 12;
   localparam int unsigned SHORT_OFF_L = 16;
   localparam int unsigned SHORT_CNT_W = 16;

   typedef enum logic [3:0] {
      OPC_SHORT_INCR = 4'd1,
      OPC_SHORT_FIX  = 4'd2,
      OPC_SET_COUNT  = 4'd9,
      OPC_WIDE_INCR  = 4'd10,
      OPC_WIDE_FIX   = 4'd11
   } opcode_e;

   typedef enum logic [1:0] {
      HK_COUNT = 2'd0,
      HK_WRITE = 2'd1,
      HK_BAD   = 2'd2
   } hdr_kind_e;

endpackage

// File: rtl/csd_hdr_decode.sv
module csd_hdr_decode
   import csd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 22,
   parameter int unsigned PAYLOAD_W = 16
) (
   input  logic [WORD_W-1:0]    word,
   output hdr_kind_e            kind,
   output logic                 incr,
   output logic                 use_pending,
   output logic [ADDR_W-1:0]    offset,
   output logic [PAYLOAD_W-1:0] count
);

   logic [ADDR_W-1:0]    wide_off;
   logic [ADDR_W-1:0]    short_off;
   logic [PAYLOAD_W-1:0] short_cnt;
   logic [PAYLOAD_W-1:0] set_cnt;
   logic [3:0]           opc;

   assign opc      = word[OPC_MSB:OPC_LSB];
   assign wide_off = word[ADDR_W-1:0];
   assign set_cnt  = word[PAYLOAD_W-1:0];

   generate
      if (ADDR_W > SHORT_OFF_W) begin : g_short_off_ext
         assign short_off = {{(ADDR_W-SHORT_OFF_W){1'b0}},
                             word[SHORT_OFF_L+SHORT_OFF_W-1:SHORT_OFF_L]};
      end else begin : g_short_off_eq
         assign short_off = word[SHORT_OFF_L+SHORT_OFF_W-1:SHORT_OFF_L];
      end
      if (PAYLOAD_W > SHORT_CNT_W) begin : g_short_cnt_ext
         assign short_cnt = {{(PAYLOAD_W-SHORT_CNT_W){1'b0}}, word[SHORT_CNT_W-1:0]};
      end else begin : g_short_cnt_eq
         assign short_cnt = word[SHORT_CNT_W-1:0];
      end
   endgenerate

   always_comb begin
      kind        = HK_BAD;
      incr        = 1'b0;
      use_pending = 1'b0;
      offset      = '0;
      count       = '0;
      case (opc)
         OPC_SET_COUNT: begin
            kind  = HK_COUNT;
            count = set_cnt;
         end
         OPC_WIDE_INCR, OPC_WIDE_FIX: begin
            kind        = HK_WRITE;
            incr        = (opc == OPC_WIDE_INCR);
            use_pending = 1'b1;
            offset      = wide_off;
         end
         OPC_SHORT_INCR, OPC_SHORT_FIX: begin
            kind   = HK_WRITE;
            incr   = (opc == OPC_SHORT_INCR);
            offset = short_off;
            count  = short_cnt;
         end
         default: kind = HK_BAD;
      endcase
   end

endmodule

// File: rtl/csd_seq.sv
module csd_seq
   import csd_pkg::*;
#(
   parameter int unsigned ADDR_W        = 22,
   parameter int unsigned PAYLOAD_W     = 16,
   parameter bit          ONE_SHOT_CNT  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [WORD_W-1:0]    cmd_word,
   output logic                 cmd_ready,
   input  logic                 slot_free,
   input  hdr_kind_e            d_kind,
   input  logic                 d_incr,
   input  logic                 d_use_pending,
   input  logic [ADDR_W-1:0]    d_offset,
   input  logic [PAYLOAD_W-1:0] d_count,
   output logic                 emit,
   output logic [ADDR_W-1:0]    emit_addr,
   output logic [WORD_W-1:0]    emit_data,
   output logic                 err
);

   localparam logic [ADDR_W-1:0]    ADDR_ONE = ADDR_W'(1);
   localparam logic [PAYLOAD_W-1:0] CNT_ONE  = PAYLOAD_W'(1);

   logic                 in_burst;
   logic                 incr_q;
   logic [ADDR_W-1:0]    cur_addr;
   logic [PAYLOAD_W-1:0] remain;
   logic [PAYLOAD_W-1:0] pending;
   logic [PAYLOAD_W-1:0] burst_cnt;
   logic                 hdr_fire;
   logic                 dat_fire;
   logic                 err_q;

   assign cmd_ready = !in_burst || slot_free;
   assign hdr_fire  = cmd_valid && !in_burst;
   assign dat_fire  = cmd_valid && in_burst && slot_free;
   assign burst_cnt = d_use_pending ? pending : d_count;

   assign emit      = dat_fire;
   assign emit_addr = cur_addr;
   assign emit_data = cmd_word;
   assign err       = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_burst <= 1'b0;
         incr_q   <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
         err_q    <= 1'b0;
      end else if (hdr_fire) begin
         case (d_kind)
            HK_WRITE: begin
               cur_addr <= d_offset;
               incr_q   <= d_incr;
               remain   <= burst_cnt;
               in_burst <= (burst_cnt != '0);
            end
            HK_BAD:  err_q <= 1'b1;
            default: ;
         endcase
      end else if (dat_fire) begin
         remain <= remain - CNT_ONE;
         if (remain == CNT_ONE) in_burst <= 1'b0;
         if (incr_q) cur_addr <= cur_addr + ADDR_ONE;
      end
   end

   generate
      if (ONE_SHOT_CNT) begin : g_oneshot_count
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pending <= '0;
            else if (hdr_fire && d_kind == HK_COUNT) pending <= d_count;
            else if (hdr_fire && d_kind == HK_WRITE && d_use_pending) pending <= '0;
         end
      end else begin : g_sticky_count
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pending <= '0;
            else if (hdr_fire && d_kind == HK_COUNT) pending <= d_count;
         end
      end
   endgenerate

   AST_NO_EMPTY_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      in_burst |-> remain != '0); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R10
   AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      dat_fire && incr_q && remain > CNT_ONE |=> cur_addr == $past(cur_addr) + ADDR_ONE); // R2
   AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dat_fire && !incr_q && remain > CNT_ONE |=> $stable(cur_addr)); // R3

endmodule

// File: rtl/csd_out_stage.sv
module csd_out_stage
   import csd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 22,
   parameter int unsigned SYNC_IDX_W  = 10,
   parameter int unsigned SYNC_COND_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [ADDR_W-1:0]      load_addr,
   input  logic [WORD_W-1:0]      load_data,
   output logic                   slot_free,
   output logic                   reg_wr_valid,
   input  logic                   reg_wr_ready,
   output logic [ADDR_W-1:0]      reg_wr_addr,
   output logic [WORD_W-1:0]      reg_wr_data,
   output logic                   sync_valid,
   output logic [SYNC_IDX_W-1:0]  sync_index,
   output logic [SYNC_COND_W-1:0] sync_cond
);

   localparam logic [ADDR_W-1:0] SYNC_ADDR = '0;

   logic              slot_v;
   logic              slot_sync;
   logic [ADDR_W-1:0] slot_addr;
   logic [WORD_W-1:0] slot_data;

   assign slot_free    = !slot_v || slot_sync || reg_wr_ready;
   assign reg_wr_valid = slot_v && !slot_sync;
   assign sync_valid   = slot_v && slot_sync;
   assign reg_wr_addr  = slot_addr;
   assign reg_wr_data  = slot_data;
   assign sync_index   = slot_data[SYNC_IDX_W-1:0];
   assign sync_cond    = slot_data[SYNC_IDX_W+SYNC_COND_W-1:SYNC_IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_v    <= 1'b0;
         slot_sync <= 1'b0;
         slot_addr <= '0;
         slot_data <= '0;
      end else if (load) begin
         slot_v    <= 1'b1;
         slot_sync <= (load_addr == SYNC_ADDR);
         slot_addr <= load_addr;
         slot_data <= load_data;
      end else if (slot_v && (slot_sync || reg_wr_ready)) begin
         slot_v    <= 1'b0;
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_valid && !reg_wr_ready
      |=> reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data)); // R9
   AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_valid && !load |=> !sync_valid); // R8
   AST_NO_LOAD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> slot_free); // R9

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
   import csd_pkg::*;
#(
   parameter int unsigned ADDR_W       = 22,
   parameter int unsigned PAYLOAD_W    = 16,
   parameter int unsigned SYNC_IDX_W   = 10,
   parameter int unsigned SYNC_COND_W  = 8,
   parameter bit          ONE_SHOT_CNT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [31:0]            cmd_word,
   output logic                   reg_wr_valid,
   input  logic                   reg_wr_ready,
   output logic [ADDR_W-1:0]      reg_wr_addr,
   output logic [31:0]            reg_wr_data,
   output logic                   sync_valid,
   output logic [SYNC_IDX_W-1:0]  sync_index,
   output logic [SYNC_COND_W-1:0] sync_cond,
   output logic                   err_flag
);

   generate
      if (ADDR_W < SHORT_OFF_W || ADDR_W > WIDE_OFF_W) begin : g_bad_addr_w
         $error("ADDR_W must lie between the short and wide offset widths");
      end
      if (PAYLOAD_W < SHORT_CNT_W || PAYLOAD_W > OPC_LSB) begin : g_bad_payload_w
         $error("PAYLOAD_W must cover the short count and stay below the opcode");
      end
      if (SYNC_IDX_W + SYNC_COND_W > WORD_W || SYNC_IDX_W == 0 || SYNC_COND_W == 0) begin : g_bad_sync_w
         $error("sync index and condition fields must fit one word");
      end
   endgenerate

   hdr_kind_e            d_kind;
   logic                 d_incr;
   logic                 d_use_pending;
   logic [ADDR_W-1:0]    d_offset;
   logic [PAYLOAD_W-1:0] d_count;
   logic                 slot_free;
   logic                 emit;
   logic [ADDR_W-1:0]    emit_addr;
   logic [WORD_W-1:0]    emit_data;

   csd_hdr_decode #(
      .ADDR_W    (ADDR_W),
      .PAYLOAD_W (PAYLOAD_W)
   ) u_decode (
      .word        (cmd_word),
      .kind        (d_kind),
      .incr        (d_incr),
      .use_pending (d_use_pending),
      .offset      (d_offset),
      .count       (d_count)
   );

   csd_seq #(
      .ADDR_W       (ADDR_W),
      .PAYLOAD_W    (PAYLOAD_W),
      .ONE_SHOT_CNT (ONE_SHOT_CNT)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_word      (cmd_word),
      .cmd_ready     (cmd_ready),
      .slot_free     (slot_free),
      .d_kind        (d_kind),
      .d_incr        (d_incr),
      .d_use_pending (d_use_pending),
      .d_offset      (d_offset),
      .d_count       (d_count),
      .emit          (emit),
      .emit_addr     (emit_addr),
      .emit_data     (emit_data),
      .err           (err_flag)
   );

   csd_out_stage #(
      .ADDR_W      (ADDR_W),
      .SYNC_IDX_W  (SYNC_IDX_W),
      .SYNC_COND_W (SYNC_COND_W)
   ) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (emit),
      .load_addr    (emit_addr),
      .load_data    (emit_data),
      .slot_free    (slot_free),
      .reg_wr_valid (reg_wr_valid),
      .reg_wr_ready (reg_wr_ready),
      .reg_wr_addr  (reg_wr_addr),
      .reg_wr_data  (reg_wr_data),
      .sync_valid   (sync_valid),
      .sync_index   (sync_index),
      .sync_cond    (sync_cond)
   );

   AST_BURST_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_valid && !reg_wr_ready && cmd_valid && cmd_ready |=> !reg_wr_valid || $stable(reg_wr_data)); // R9

endmodule

// File: tb/cmd_stream_decoder_bench.sv
`timescale 1ns/1ps
module cmd_stream_decoder_bench;

   localparam int AW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [31:0]   cmd_word = '0;
   logic          reg_wr_valid;
   logic          reg_wr_ready = 1'b1;
   logic [AW-1:0] reg_wr_addr;
   logic [31:0]   reg_wr_data;
   logic          sync_valid;
   logic [9:0]    sync_index;
   logic [7:0]    sync_cond;
   logic          err_flag;

   always #10 clk = ~clk;

   cmd_stream_decoder u_cmd_stream_decoder (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .cmd_word     (cmd_word),
      .reg_wr_valid (reg_wr_valid),
      .reg_wr_ready (reg_wr_ready),
      .reg_wr_addr  (reg_wr_addr),
      .reg_wr_data  (reg_wr_data),
      .sync_valid   (sync_valid),
      .sync_index   (sync_index),
      .sync_cond    (sync_cond),
      .err_flag     (err_flag)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   bit    bp_en = 1'b0;
   bit    q_sync[$];
   int    q_addr[$];
   int    q_data[$];
   string q_tag[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic exp_w(input int addr, input int data, input string tag);
      q_sync.push_back(1'b0); q_addr.push_back(addr);
      q_data.push_back(data); q_tag.push_back(tag);
   endtask

   task automatic exp_s(input int idx, input int cond, input string tag);
      q_sync.push_back(1'b1); q_addr.push_back(idx);
      q_data.push_back(cond); q_tag.push_back(tag);
   endtask

   task automatic send(input logic [31:0] w);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word  = w;
      #1;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   function automatic logic [31:0] hdr_short(input logic [3:0] op, input int off, input int cnt);
      return {op, 12'(off), 16'(cnt)};
   endfunction

   function automatic logic [31:0] hdr_wide(input logic [3:0] op, input int off);
      return {op, 6'b0, 22'(off)};
   endfunction

   task automatic drain();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (q_sync.size() == 0 && !reg_wr_valid && !sync_valid) break;
      end
   endtask

   // pseudo-random ready for the register file, changed away from the edge
   initial begin
      logic [7:0] lf = 8'hA7;
      forever begin
         @(posedge clk);
         #2;
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         reg_wr_ready = bp_en ? lf[0] : 1'b1;
      end
   end

   // monitor / scoreboard
   bit          stall_seen = 1'b0;
   logic [AW-1:0] stall_addr;
   logic [31:0] stall_data;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (stall_seen) begin
            chk(reg_wr_valid && reg_wr_addr == stall_addr && reg_wr_data == stall_data,
                "R9", "held write", {reg_wr_addr, reg_wr_data}, {stall_addr, stall_data});
         end
         stall_seen = reg_wr_valid && !reg_wr_ready;
         stall_addr = reg_wr_addr;
         stall_data = reg_wr_data;
         if (reg_wr_valid && reg_wr_ready) begin
            if (q_sync.size() == 0) begin
               chk(1'b0, "R9", "unexpected write addr", reg_wr_addr, 0);
            end else begin
               automatic bit    s = q_sync.pop_front();
               automatic int    a = q_addr.pop_front();
               automatic int    d = q_data.pop_front();
               automatic string t = q_tag.pop_front();
               chk(!s, t, "kind (write seen, sync expected)", 0, 1);
               chk(reg_wr_addr == AW'(a), t, "write addr", reg_wr_addr, a);
               chk(reg_wr_data == 32'(d), t, "write data", reg_wr_data, d);
            end
         end
         if (sync_valid) begin
            if (q_sync.size() == 0) begin
               chk(1'b0, "R8", "unexpected sync index", sync_index, 0);
            end else begin
               automatic bit    s = q_sync.pop_front();
               automatic int    a = q_addr.pop_front();
               automatic int    d = q_data.pop_front();
               automatic string t = q_tag.pop_front();
               chk(s, t, "kind (sync seen, write expected)", 1, 0);
               chk(sync_index == 10'(a), t, "sync index", sync_index, a);
               chk(sync_cond == 8'(d), t, "sync cond", sync_cond, d);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(!reg_wr_valid && !sync_valid, "R11", "outputs idle", {reg_wr_valid, sync_valid}, 0);
      chk(!err_flag, "R11", "err_flag", err_flag, 0);
      chk(cmd_ready, "R11", "cmd_ready", cmd_ready, 1);

      // R1 + R2: set count 3, wide incrementing burst
      send({4'h9, 12'h0, 16'd3});
      send(hdr_wide(4'hA, 'h100));
      for (int i = 0; i < 3; i++) begin
         exp_w('h100 + i, 'hD000_0010 + i, "R2");
         send(32'hD000_0010 + i);
      end
      drain();

      // R3: fixed wide burst at the top offset
      send({4'h9, 12'h0, 16'd2});
      send(hdr_wide(4'hB, 'h3F_FFFF));
      for (int i = 0; i < 2; i++) begin
         exp_w('h3F_FFFF, 'hB000_0020 + i, "R3");
         send(32'hB000_0020 + i);
      end

      // R6: count was consumed, so this wide header takes no data
      send(hdr_wide(4'hA, 'h50));
      // R4: short incrementing burst follows straight after
      send(hdr_short(4'h1, 'h0AB, 4));
      for (int i = 0; i < 4; i++) begin
         exp_w('h0AB + i, 'h1100_0000 + i, "R4");
         send(32'h1100_0000 + i);
      end
      // R6: explicit zero count, then a wide fixed header takes nothing
      send({4'h9, 12'h0, 16'd0});
      send(hdr_wide(4'hB, 'h77));
      // R5: short fixed burst at the top short offset
      send(hdr_short(4'h2, 'hFFF, 2));
      for (int i = 0; i < 2; i++) begin
         exp_w('hFFF, 'h2200_0000 + i, "R5");
         send(32'h2200_0000 + i);
      end
      // R7: short count zero, next word is a header
      send(hdr_short(4'h1, 'h5, 0));
      send(hdr_short(4'h1, 'h9, 1));
      exp_w('h9, 'h7700_0001, "R7");
      send(32'h7700_0001);
      drain();
      chk(q_sync.size() == 0, "R6", "pending expectations", q_sync.size(), 0);

      // R10: unknown opcode
      @(negedge clk);
      chk(!err_flag, "R10", "err_flag before unknown", err_flag, 0);
      send(32'h7000_0003);
      @(negedge clk);
      chk(err_flag, "R10", "err_flag after unknown", err_flag, 1);
      send(hdr_short(4'h2, 'h33, 1));
      exp_w('h33, 'h0A0A_0A0A, "R10");
      send(32'h0A0A_0A0A);
      drain();

      // R9: backpressure across a long incrementing burst
      bp_en = 1'b1;
      send(hdr_short(4'h1, 'h200, 12));
      for (int i = 0; i < 12; i++) begin
         exp_w('h200 + i, 'h9900_0000 + i * 3, "R9");
         send(32'h9900_0000 + i * 3);
      end
      drain();
      bp_en = 1'b0;
      chk(q_sync.size() == 0, "R9", "words lost under stall", q_sync.size(), 0);

      // R8: sync increment through a fixed write to address 0
      send(hdr_short(4'h2, 0, 1));
      exp_s('h3A5, 'h81, "R8");
      send({14'h0, 8'h81, 10'h3A5});
      // R8: wide incrementing burst starting at 0: sync then register 1
      send({4'h9, 12'h0, 16'd2});
      send(hdr_wide(4'hA, 0));
      exp_s('h012, 'hFE, "R8");
      send({14'h0, 8'hFE, 10'h012});
      exp_w(1, 'h4444_5555, "R8");
      send(32'h4444_5555);
      drain();

      chk(q_sync.size() == 0, "R8", "pending expectations", q_sync.size(), 0);
      chk(err_flag, "R10", "err_flag still set", err_flag, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule